// File: doc/BRIEF.md
# Predicated Contiguous Prefetch Sequencer

This block takes one 32-bit vector prefetch instruction word, checks it against a fixed opcode pattern and splits its variable fields apart. It then walks the byte elements of a vector whose length is set by a parameter. Each byte element has one bit in a governing predicate mask. For every element whose bit is set, the block emits one prefetch request. The request address is the base register plus the offset register plus the element index, computed in 64 bits with wraparound. The offset register is only read and is never written.

The block reads three things from its neighbours. It gets the predicate mask by driving a predicate index. It gets the base and offset general registers through a one-cycle read strobe that carries two register indices, and it takes a stack-pointer value as well. Requests go out on a valid/ready port. Each run ends with either a one-cycle `done` pulse or a one-cycle `undef` pulse.

The controller has six states. S_IDLE waits for `start`. S_DECODE checks the latched word and samples the predicate. S_FETCH reads the registers and forms base plus offset. S_ISSUE emits one request per active element. S_DONE pulses completion. S_UNDEF pulses the undefined flag.

The transitions are:
- idle→decode when `start` is high.
- decode→undef when the word is illegal.
- decode→done when the predicate is empty.
- decode→fetch otherwise.
- fetch→issue always.
- issue→done when the last active element is accepted.
- done→idle and undef→idle always.

Top module: `pfs_seq`

## Requirements
- R1: A word is legal only when (instr & 32'hFFE0_E010) == 32'h8400_C000. An illegal word raises `undef` for one cycle, two cycles after the `start` edge. It issues no request, performs no register read and gives no `done`.
- R2: An offset-register field instr[20:16] equal to 31 is treated as undefined in the same way as R1.
- R3: The base register index is instr[9:5]. When this field is 31, `sp_value` is used as the base instead of `rd_base_data`.
- R4: Every request carries three attributes taken from instr[3:0]. `req_write` is bit 3. `req_level` is bits 2:1, and the value 3 is issued like any other. `req_stream` is bit 1 of nothing else: it is bit 0.
- R5: The predicate index driven on `pred_idx` is instr[12:10]. The mask has VLEN/8 bits, one per byte element. Exactly one request is accepted for each set bit.
- R6: Requests are issued in ascending element order, and elements whose bit is clear are skipped.
- R7: The request address for element e is base + offset + e, modulo 2^64.
- R8: If the mask is all zero, the block makes no register read and issues no request. `done` is high two cycles after the `start` edge.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and the three attributes stay unchanged.
- R10: `done` lasts one cycle and rises in the cycle after the last accepted request. `busy` is high from the cycle after `start` until the block returns to S_IDLE.
- R11: `start` is ignored while `busy` is high. A word presented during a run changes neither the current run nor the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with `instr` (accepted in S_IDLE only) |
| instr | input | 32 | Prefetch instruction word |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle undefined-instruction pulse |
| pred_idx | output | 3 | Governing predicate register index |
| pred_mask | input | VLEN/8 | Mask of the selected predicate, one bit per byte |
| rd_req | output | 1 | Register read strobe; data are taken in the same cycle |
| rd_base_idx | output | 5 | Base register index |
| rd_off_idx | output | 5 | Offset register index |
| rd_base_data | input | 64 | Base register value |
| rd_off_data | input | 64 | Offset register value |
| sp_value | input | 64 | Stack pointer value |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Prefetch request accepted |
| req_addr | output | 64 | Prefetch byte address |
| req_write | output | 1 | 1 = write intent, 0 = read intent |
| req_level | output | 2 | Target cache level code |
| req_stream | output | 1 | 1 = streaming, 0 = keep |

## Verification
Some properties are checked by assertions on every cycle:
- A stalled request keeps its address and attributes.
- Accepted elements rise strictly in index.
- A register read never happens with an empty working mask.
- `done` is never longer than one cycle.

Other properties can only be shown by the bench's scenarios, because they compare against values computed outside the block:
- Exact addresses for each element, including wraparound past 2^64.
- Stack-pointer substitution.
- Attribute decoding for all sixteen prefetch-operation codes.
- Rejection of every single-bit corruption of the fixed opcode.
- The exact cycle of `done` and `undef`.
- That a second `start` during a run has no effect.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int ADDR_W = 64;
    localparam int RIDX_W = 5;
    localparam int PG_W   = 3;

    // Fixed opcode bits: [31:25], [24:21], [15:13] and [4].
    localparam logic [31:0] FIX_MASK = 32'hFFE0_E010;
    localparam logic [31:0] FIX_VAL  = 32'h8400_C000;
    localparam logic [RIDX_W-1:0] LAST_REG = 5'd31;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_FETCH,
        S_ISSUE,
        S_DONE,
        S_UNDEF
    } seq_state_e;

    typedef struct packed {
        logic [RIDX_W-1:0] off_reg;
        logic [PG_W-1:0]   pg;
        logic [RIDX_W-1:0] base_reg;
        logic              write;
        logic [1:0]        level;
        logic              stream;
    } pf_op_t;

endpackage

// File: rtl/pfs_decode.sv
module pfs_decode
    import pfs_pkg::*;
(
    input  logic [31:0] instr,
    output pf_op_t      op,
    output logic        illegal
);

    logic fixed_ok;
    logic off_bad;

    always_comb begin
        op.off_reg  = instr[20:16];
        op.pg       = instr[12:10];
        op.base_reg = instr[9:5];
        op.write    = instr[3];
        op.level    = instr[2:1];
        op.stream   = instr[0];
    end

    assign fixed_ok = ((instr & FIX_MASK) == FIX_VAL);
    assign off_bad  = (instr[20:16] == LAST_REG);
    assign illegal  = !fixed_ok || off_bad;

endmodule

// File: rtl/pfs_first_set.sv
module pfs_first_set #(
    parameter int NE = 32,
    localparam int IW = $clog2(NE)
) (
    input  logic [NE-1:0] vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    logic [NE-1:0] lower;   // some bit below position i is set
    logic [NE-1:0] hit;

    assign lower[0] = 1'b0;
    for (genvar i = 1; i < NE; i++) begin : g_chain
        assign lower[i] = lower[i-1] | vec[i-1];
    end
    for (genvar i = 0; i < NE; i++) begin : g_hit
        assign hit[i] = vec[i] & ~lower[i];
    end

    assign any = lower[NE-1] | vec[NE-1];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NE; i++) begin
            if (hit[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

endmodule

// File: rtl/pfs_addr_gen.sv
module pfs_addr_gen
    import pfs_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic              base_is_sp,
    input  logic [ADDR_W-1:0] gpr_base,
    input  logic [ADDR_W-1:0] sp_base,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] sum_q,
    input  logic [IW-1:0]     elem_idx,
    output logic [ADDR_W-1:0] sum,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_sel;

    assign base_sel = base_is_sp ? sp_base : gpr_base;
    assign sum      = base_sel + offset;
    assign addr     = sum_q + ADDR_W'(elem_idx);

endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
    import pfs_pkg::*;
#(
    parameter int VLEN = 256,
    localparam int NE = VLEN / 8,
    localparam int IW = $clog2(NE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    output logic              busy,
    output logic              done,
    output logic              undef,
    output logic [PG_W-1:0]   pred_idx,
    input  logic [NE-1:0]     pred_mask,
    output logic              rd_req,
    output logic [RIDX_W-1:0] rd_base_idx,
    output logic [RIDX_W-1:0] rd_off_idx,
    input  logic [ADDR_W-1:0] rd_base_data,
    input  logic [ADDR_W-1:0] rd_off_data,
    input  logic [ADDR_W-1:0] sp_value,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_write,
    output logic [1:0]        req_level,
    output logic              req_stream
);

    seq_state_e        state_q, state_d;
    logic [31:0]       instr_q;
    pf_op_t            op;
    logic              illegal;
    logic [NE-1:0]     work_q;
    logic [ADDR_W-1:0] sum_q;
    logic [ADDR_W-1:0] sum_w;
    logic              any_left;
    logic [IW-1:0]     cur_idx;
    logic [NE-1:0]     remain;
    logic              accept;

    pfs_decode u_decode (
        .instr   (instr_q),
        .op      (op),
        .illegal (illegal)
    );

    pfs_first_set #(.NE(NE)) u_first (
        .vec (work_q),
        .any (any_left),
        .idx (cur_idx)
    );

    pfs_addr_gen #(.IW(IW)) u_addr (
        .base_is_sp (op.base_reg == LAST_REG),
        .gpr_base   (rd_base_data),
        .sp_base    (sp_value),
        .offset     (rd_off_data),
        .sum_q      (sum_q),
        .elem_idx   (cur_idx),
        .sum        (sum_w),
        .addr       (req_addr)
    );

    assign accept = req_valid && req_ready;
    assign remain = work_q & ~(NE'(1) << cur_idx);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_DECODE;
            S_DECODE: begin
                if (illegal)          state_d = S_UNDEF;
                else if (~|pred_mask) state_d = S_DONE;
                else                  state_d = S_FETCH;
            end
            S_FETCH:  state_d = S_ISSUE;
            S_ISSUE:  if (accept && ~|remain) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            S_UNDEF:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            work_q  <= '0;
            sum_q   <= '0;
        end else begin
            if (state_q == S_IDLE && start) instr_q <= instr;
            if (state_q == S_DECODE)        work_q  <= pred_mask;
            else if (accept)                work_q  <= remain;
            if (state_q == S_FETCH)         sum_q   <= sum_w;
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        rd_req      = (state_q == S_FETCH);
        req_valid   = (state_q == S_ISSUE);
        done        = (state_q == S_DONE);
        undef       = (state_q == S_UNDEF);
        pred_idx    = op.pg;
        rd_base_idx = op.base_reg;
        rd_off_idx  = op.off_reg;
        req_write   = op.write;
        req_level   = op.level;
        req_stream  = op.stream;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)
                                      && $stable(req_level) && $stable(req_stream))); // R9
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_valid || (cur_idx > $past(cur_idx)))); // R6
    AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> any_left); // R5
    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> any_left); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

// File: tb/pfs_seq_tb.sv
`timescale 1ns/1ps
module pfs_seq_tb;

    localparam int VLEN = 128;
    localparam int NE = VLEN / 8;
    localparam logic [31:0] FMASK = 32'hFFE0_E010;
    localparam logic [31:0] FVAL  = 32'h8400_C000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] instr = '0;
    logic busy, done, undef, rd_req, req_valid, req_write, req_stream;
    logic [2:0] pred_idx;
    logic [NE-1:0] pred_mask;
    logic [4:0] rd_base_idx, rd_off_idx;
    logic [63:0] rd_base_data, rd_off_data, req_addr;
    logic [63:0] sp_value = 64'hFFFF_FFFF_FFFF_FFF8;
    logic req_ready = 1'b0;
    logic [1:0] req_level;

    logic [63:0] gpr [0:31];
    logic [NE-1:0] pmask [0:7];
    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    assign pred_mask    = pmask[pred_idx];
    assign rd_base_data = gpr[rd_base_idx];
    assign rd_off_data  = gpr[rd_off_idx];

    pfs_seq #(.VLEN(VLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .undef(undef),
        .pred_idx(pred_idx), .pred_mask(pred_mask),
        .rd_req(rd_req), .rd_base_idx(rd_base_idx), .rd_off_idx(rd_off_idx),
        .rd_base_data(rd_base_data), .rd_off_data(rd_off_data), .sp_value(sp_value),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_level(req_level), .req_stream(req_stream)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [4:0] rm, input logic [2:0] pg,
                                        input logic [4:0] rn, input logic [3:0] op);
        return FVAL | (32'(rm) << 16) | (32'(pg) << 10) | (32'(rn) << 5) | 32'(op);
    endfunction

    function automatic logic next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[16];
    endfunction

    task automatic run_case(input logic [31:0] iw, input int rmode, input bit poke);
        logic [4:0] rm, rn;
        logic [2:0] pg;
        logic [3:0] op;
        logic [NE-1:0] m;
        logic [63:0] base, off, held;
        bit exp_undef, hold_pend, r;
        int n, next_e, got, reads, done_n, undef_n, last_hs, pc, e;
        rm = iw[20:16]; pg = iw[12:10]; rn = iw[9:5]; op = iw[3:0];
        exp_undef = ((iw & FMASK) != FVAL) || (rm == 5'd31);
        m = pmask[pg];
        base = (rn == 5'd31) ? sp_value : gpr[rn];
        off = gpr[rm];
        pc = $countones(m);
        @(negedge clk); start = 1'b1; instr = iw;
        @(negedge clk);
        if (poke) instr = ~iw; else start = 1'b0;
        n = 1; next_e = 0; got = 0; reads = 0; done_n = -1; undef_n = -1;
        last_hs = -1; hold_pend = 0; held = '0;
        while (n < 200) begin
            if (hold_pend) chk(req_valid && req_addr == held, "R9 stall hold", req_addr, held);
            hold_pend = 0;
            if (rd_req) reads++;
            if (undef) undef_n = n;
            if (done) done_n = n;
            r = (rmode == 1) ? 1'b1 : next_rand();
            req_ready = r;
            if (req_valid) begin
                e = next_e;
                while (e < NE && !m[e]) e++;
                if (e >= NE) begin
                    chk(1'b0, "R5 extra request", req_addr, 64'd0);
                end else begin
                    chk(req_addr == base + off + 64'(e), "R7/R3/R6 address", req_addr, base + off + 64'(e));
                    chk({req_write, req_level, req_stream} == op, "R4 attributes",
                        64'({req_write, req_level, req_stream}), 64'(op));
                    if (r) begin got++; next_e = e + 1; last_hs = n; end
                    else begin hold_pend = 1; held = req_addr; end
                end
            end
            if (done_n >= 0 || undef_n >= 0) break;
            @(negedge clk); n++;
            if (n == 3) start = 1'b0;
        end
        req_ready = 1'b0;
        chk((undef_n >= 0) == exp_undef, "R1/R2 undef flag", 64'(undef_n >= 0), 64'(exp_undef));
        if (exp_undef) begin
            chk(got == 0 && reads == 0 && done_n < 0 && undef_n == 2, "R2 undef quiet",
                64'(got + reads), 64'd0);
        end else begin
            chk(got == pc, "R5 request count", 64'(got), 64'(pc));
            chk(done_n == ((pc == 0) ? 2 : last_hs + 1), "R10/R8 done cycle", 64'(done_n),
                64'((pc == 0) ? 2 : last_hs + 1));
            chk(reads == ((pc == 0) ? 0 : 1), "R8 register reads", 64'(reads), 64'((pc == 0) ? 0 : 1));
        end
        @(negedge clk);
        chk(!busy && !done && !undef, "R10/R11 back to idle", 64'({busy, done, undef}), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) gpr[i] = 64'h0123_4567_89AB_CDEF * 64'(i + 1) + 64'h11;
        gpr[7] = 64'hFFFF_FFFF_FFFF_FFFA;
        for (int i = 0; i < 8; i++) pmask[i] = NE'(16'hA5C3 ^ (16'h1111 * i));
        pmask[0] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid && !done && !undef && !busy && !rd_req, "R10 reset state",
            64'({req_valid, done, undef, busy, rd_req}), 64'd0);
        // R4: all operation codes, including the level code 3 ones
        for (int op = 0; op < 16; op++) run_case(enc(5'd3, 3'd2, 5'd4, 4'(op)), 0, 0);
        // R5 R6: walking single bits on predicate 5, back-to-back acceptance
        for (int b = 0; b < NE; b++) begin
            pmask[5] = NE'(1) << b;
            run_case(enc(5'd9, 3'd5, 5'd10, 4'd1), 1, 0);
        end
        pmask[5] = '1;
        run_case(enc(5'd9, 3'd5, 5'd10, 4'd12), 1, 0);
        // R8: empty predicate
        run_case(enc(5'd2, 3'd0, 5'd1, 4'd0), 0, 0);
        // R3 R7: stack pointer base and wrap past 2^64
        run_case(enc(5'd7, 3'd3, 5'd31, 4'd5), 0, 0);
        run_case(enc(5'd7, 3'd4, 5'd6, 4'd9), 0, 0);
        // R2: offset field 31
        run_case(enc(5'd31, 3'd3, 5'd4, 4'd0), 0, 0);
        // R1: each fixed bit corrupted
        for (int i = 0; i < 32; i++)
            if (FMASK[i]) run_case(enc(5'd3, 3'd3, 5'd4, 4'd0) ^ (32'd1 << i), 0, 0);
        // R11: start held with another word during a run
        run_case(enc(5'd3, 3'd6, 5'd8, 4'd3), 0, 1);
        // R5 R6 R9: pseudo-random masks and stalls
        for (int k = 0; k < 120; k++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            pmask[1] = NE'(lcg[31:8]);
            run_case(enc(5'(k % 30), 3'd1, 5'((k * 7) % 32), 4'(k)), 0, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule